// File: doc/BRIEF.md
# Timer Output Pin Controller

This block owns one general-purpose output pin. The pin can carry ordinary port data, or it can carry a timer-derived waveform. A two-bit source field in the timer mode register picks the source. In the two timer modes, the pin is driven by a toggle flop. Each end-of-count pulse from the chosen timer inverts that flop, and setting that timer's load bit forces the flop high. The fourth source puts the internal clock, divided by two, on the pin. The timers and prescalers sit outside this block and deliver only single-cycle end-of-count pulses.

While the pin is in any timer or clock source mode, software writes to the port register cannot move the pin. A read of the port register always shows the level really present on the pin. Every source goes through one output register, so switching sources never produces a glitch. The pin therefore follows its source state one clock later.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: After reset the source field is 00, the toggle flop holds 1, the port register holds PORT_RST, and the pin shows bit PIN_IDX of PORT_RST; the first switch to a timer source without a load shows 1 on the pin.
- R2: The source field sits at bits 7:6 of the mode write data: 00 port data, 01 timer 0 toggle, 10 timer 1 toggle, 11 divided clock. The field changes only on a mode write, and the pin shows the chosen source's state as it stood before the last clock edge (one cycle of latency).
- R3: In source 01 or 10, each end-of-count pulse of the selected timer inverts the toggle flop.
- R4: End-of-count pulses from the timer that is not selected, or any pulse in source 00 or 11, leave the toggle flop unchanged.
- R5: A mode write whose source field is 01 with bit 0 set, or 10 with bit 1 set, forces the toggle flop to 1. A load wins over an end-of-count pulse in the same cycle.
- R6: A single mode write that carries the timer source and the load bit starts the pin at 1.
- R7: In source 11 the pin inverts on every clock, giving half the clock frequency.
- R8: A port write stores all bits of port_wdata_i, except bit PIN_IDX, which is stored only while the source field is 00.
- R9: port_rdata_o returns the stored port bits, with bit PIN_IDX replaced by the current pin level.
- R10: With source 01 and end-of-count pulses every N cycles, the pin is a square wave high for exactly half of any 8N-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_we_i | input | 1 | Write strobe for the timer mode register |
| mode_wdata_i | input | DATA_W | Mode write data: source at 7:6, load bits at 1 and 0 |
| port_we_i | input | 1 | Write strobe for the port data register |
| port_wdata_i | input | DATA_W | Port write data |
| eoc0_i | input | 1 | Timer 0 end-of-count pulse |
| eoc1_i | input | 1 | Timer 1 end-of-count pulse |
| pin_o | output | 1 | Pin level |
| port_rdata_o | output | DATA_W | Port register readback, with pin level at PIN_IDX |

## Verification
The bench builds the block with DATA_W of 8, PIN_IDX of 6, PORT_RST of zero and a two-stage reset synchronizer. A zero reset value makes the pin start low while the toggle flop starts high. This lets the first switch into a timer source expose the flop's reset state. With the pin bit at 6, written bits sit on both sides of the spliced readback bit. This shows whether the lockout and the splice affect only that one position.

// File: rtl/tmr_pin_pkg.sv
`timescale 1ns/1ps
package tmr_pin_pkg;
  typedef enum logic [1:0] {
    SRC_PORT = 2'b00,
    SRC_T0   = 2'b01,
    SRC_T1   = 2'b10,
    SRC_CLK  = 2'b11
  } src_e;

  localparam int SRC_LSB   = 6;
  localparam int LOAD0_BIT = 0;
  localparam int LOAD1_BIT = 1;
endpackage

// File: rtl/tmr_pin_rst_sync.sv
`timescale 1ns/1ps
module tmr_pin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_pin_src_reg.sv
`timescale 1ns/1ps
module tmr_pin_src_reg
  import tmr_pin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wsrc_i,
  output src_e       src_o
);
  src_e src_q, src_d;
  logic src_en;

  always_comb begin
    src_en = we_i;
    src_d  = src_e'(wsrc_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     src_q <= SRC_PORT;
    else if (src_en) src_q <= src_d;
  end

  assign src_o = src_q;

  // R2: source field moves only on a mode write
  a_r2_src_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(src_q));
endmodule

// File: rtl/tmr_pin_toggle.sv
`timescale 1ns/1ps
module tmr_pin_toggle
  import tmr_pin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  src_e       src_i,
  input  logic       mode_we_i,
  input  logic [1:0] wsrc_i,
  input  logic [1:0] wload_i,
  input  logic       eoc0_i,
  input  logic       eoc1_i,
  output logic       tff_o
);
  logic tff_q, tff_d, tff_en;
  logic load_hit, eoc_hit;

  always_comb begin
    load_hit = mode_we_i &&
               ((wsrc_i == SRC_T0 && wload_i[LOAD0_BIT]) ||
                (wsrc_i == SRC_T1 && wload_i[LOAD1_BIT]));
    eoc_hit  = (src_i == SRC_T0 && eoc0_i) || (src_i == SRC_T1 && eoc1_i);
    tff_en   = load_hit || eoc_hit;
    tff_d    = tff_q;
    if (load_hit)     tff_d = 1'b1;
    else if (eoc_hit) tff_d = ~tff_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tff_q <= 1'b1;
    else if (tff_en) tff_q <= tff_d;
  end

  assign tff_o = tff_q;

  // R3: selected end-of-count inverts the flop
  a_r3_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_hit && !load_hit) |=> (tff_q != $past(tff_q)));
  // R4: nothing else moves the flop
  a_r4_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_hit && !(src_i == SRC_T0 && eoc0_i) && !(src_i == SRC_T1 && eoc1_i))
      |=> $stable(tff_q));
  // R5: a load leaves the flop at 1, even against a pulse
  a_r5_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_hit |=> tff_q);
endmodule

// File: rtl/tmr_pin_clkdiv.sv
`timescale 1ns/1ps
module tmr_pin_clkdiv (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o
);
  logic div_q, div_d;

  always_comb div_d = ~div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= div_d;
  end

  assign div_o = div_q;

  // R7: divider alternates every clock
  a_r7_div_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (div_q != $past(div_q)));
endmodule

// File: rtl/tmr_pin_out.sv
`timescale 1ns/1ps
module tmr_pin_out
  import tmr_pin_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                PIN_IDX  = 6,
  parameter logic [DATA_W-1:0] PORT_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_e              src_i,
  input  logic              tff_i,
  input  logic              div_i,
  input  logic              port_we_i,
  input  logic [DATA_W-1:0] port_wdata_i,
  output logic              pin_o,
  output logic [DATA_W-1:0] port_rdata_o
);
  logic [DATA_W-1:0] port_q, port_d;
  logic              pin_q, pin_d;
  logic              pin_wr_ok;

  always_comb begin
    pin_wr_ok = (src_i == SRC_PORT);
    port_d    = port_q;
    if (port_we_i) begin
      for (int i = 0; i < DATA_W; i++) begin
        if (i != PIN_IDX || pin_wr_ok) port_d[i] = port_wdata_i[i];
      end
    end
  end

  always_comb begin
    unique case (src_i)
      SRC_PORT: pin_d = port_q[PIN_IDX];
      SRC_CLK:  pin_d = div_i;
      default:  pin_d = tff_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        port_q <= PORT_RST;
    else if (port_we_i) port_q <= port_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= PORT_RST[PIN_IDX];
    else         pin_q <= pin_d;
  end

  generate
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rd
      if (gi == PIN_IDX) begin : g_pin
        assign port_rdata_o[gi] = pin_q;
      end else begin : g_reg
        assign port_rdata_o[gi] = port_q[gi];
      end
    end
  endgenerate

  assign pin_o = pin_q;

  // R8: port writes cannot reach the pin bit outside port mode
  a_r8_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_we_i && src_i != SRC_PORT) |=> $stable(port_q[PIN_IDX]));
  // R7: pin alternates while the clock source is held
  a_r7_pin_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_CLK && $past(src_i) == SRC_CLK) |=> (pin_q != $past(pin_q)));
  // R3: in timer mode the pin follows the flop one cycle later
  a_r3_pin_tff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_T0 || src_i == SRC_T1) |=> (pin_q == $past(tff_i)));
endmodule

// File: rtl/tmr_pin_ctrl.sv
`timescale 1ns/1ps
module tmr_pin_ctrl
  import tmr_pin_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                PIN_IDX     = 6,
  parameter logic [DATA_W-1:0] PORT_RST    = '0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [DATA_W-1:0] mode_wdata_i,
  input  logic              port_we_i,
  input  logic [DATA_W-1:0] port_wdata_i,
  input  logic              eoc0_i,
  input  logic              eoc1_i,
  output logic              pin_o,
  output logic [DATA_W-1:0] port_rdata_o
);
  logic       rst_int_n;
  src_e       src;
  logic       tff, div;
  logic [1:0] wsrc, wload;

  assign wsrc  = mode_wdata_i[SRC_LSB +: 2];
  assign wload = {mode_wdata_i[LOAD1_BIT], mode_wdata_i[LOAD0_BIT]};

  tmr_pin_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_int_n));

  tmr_pin_src_reg u_src (
    .clk_i(clk_i), .rst_ni(rst_int_n), .we_i(mode_we_i),
    .wsrc_i(wsrc), .src_o(src));

  tmr_pin_toggle u_tff (
    .clk_i(clk_i), .rst_ni(rst_int_n), .src_i(src), .mode_we_i(mode_we_i),
    .wsrc_i(wsrc), .wload_i(wload), .eoc0_i(eoc0_i), .eoc1_i(eoc1_i),
    .tff_o(tff));

  tmr_pin_clkdiv u_div (
    .clk_i(clk_i), .rst_ni(rst_int_n), .div_o(div));

  tmr_pin_out #(.DATA_W(DATA_W), .PIN_IDX(PIN_IDX), .PORT_RST(PORT_RST)) u_out (
    .clk_i(clk_i), .rst_ni(rst_int_n), .src_i(src), .tff_i(tff), .div_i(div),
    .port_we_i(port_we_i), .port_wdata_i(port_wdata_i),
    .pin_o(pin_o), .port_rdata_o(port_rdata_o));
endmodule

// File: tb/tmr_pin_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_pin_ctrl_bench;
  localparam int PIN = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0, port_we = 1'b0, eoc0 = 1'b0, eoc1 = 1'b0;
  logic [7:0] mode_wd = '0, port_wd = '0;
  logic       pin_o;
  logic [7:0] rdata;

  int nvec = 0, nfail = 0;
  bit [1:0] m_sel;
  bit       m_tff, m_div, m_pin;
  bit [7:0] m_port;

  always #4 clk = ~clk;

  tmr_pin_ctrl u_tmr_pin_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
    .port_we_i(port_we), .port_wdata_i(port_wd), .eoc0_i(eoc0), .eoc1_i(eoc1),
    .pin_o(pin_o), .port_rdata_o(rdata));

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    bit ld, hit, npin;
    bit [7:0] np, erd;
    @(posedge clk);
    ld  = mode_we && ((mode_wd[7:6] == 2'b01 && mode_wd[0]) ||
                      (mode_wd[7:6] == 2'b10 && mode_wd[1]));
    hit = (m_sel == 2'b01 && eoc0) || (m_sel == 2'b10 && eoc1);
    npin = (m_sel == 2'b00) ? m_port[PIN] : (m_sel == 2'b11) ? m_div : m_tff;
    np = m_port;
    if (port_we)
      for (int i = 0; i < 8; i++)
        if (i != PIN || m_sel == 2'b00) np[i] = port_wd[i];
    if (ld) m_tff = 1'b1;
    else if (hit) m_tff = ~m_tff;
    m_div  = ~m_div;
    m_port = np;
    m_pin  = npin;
    if (mode_we) m_sel = mode_wd[7:6];
    @(negedge clk);
    erd = m_port;
    erd[PIN] = m_pin;
    check(tag, "pin", {7'b0, pin_o}, {7'b0, m_pin});
    check(tag, "readback", rdata, erd);
    mode_we = 1'b0; port_we = 1'b0; eoc0 = 1'b0; eoc1 = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_sel = 2'b00; m_tff = 1'b1; m_div = 1'b0; m_pin = 1'b0; m_port = 8'h00;
    // R1: reset state at the ports
    check("R1", "pin", {7'b0, pin_o}, 8'h00);
    check("R1", "readback", rdata, 8'h00);
    idle(2, "R1");

    // R8 / R9: port mode writes reach the pin
    port_we = 1'b1; port_wd = 8'hC3; cyc("R8");
    idle(2, "R9");
    port_we = 1'b1; port_wd = 8'h05; cyc("R8");
    idle(2, "R2");

    // R1: timer 0 source without load shows the reset flop value
    mode_we = 1'b1; mode_wd = 8'h40; cyc("R1");
    idle(2, "R1");
    // R3: timer 0 pulses toggle
    eoc0 = 1'b1; cyc("R3"); idle(2, "R3");
    eoc0 = 1'b1; cyc("R3"); idle(2, "R3");
    // R4: timer 1 pulses ignored
    eoc1 = 1'b1; cyc("R4"); idle(2, "R4");
    // R8: port write locked out of pin bit, others stored
    port_we = 1'b1; port_wd = 8'hFA; cyc("R8"); idle(2, "R9");
    // R5: load against a pulse in the same cycle
    eoc0 = 1'b1; cyc("R3"); idle(1, "R3");
    mode_we = 1'b1; mode_wd = 8'h41; eoc0 = 1'b1; cyc("R5");
    idle(2, "R5");

    // R6: switch to timer 1 with its load in one write
    eoc0 = 1'b1; cyc("R4");
    mode_we = 1'b1; mode_wd = 8'h82; cyc("R6");
    idle(2, "R6");
    eoc1 = 1'b1; cyc("R3"); idle(2, "R3");
    eoc0 = 1'b1; cyc("R4"); idle(2, "R4");

    // R10: continuous counting on timer 0, period 4
    mode_we = 1'b1; mode_wd = 8'h43; cyc("R6");
    idle(3, "R10");
    highs = 0;
    for (int k = 0; k < 40; k++) begin
      if (k % 4 == 3) eoc0 = 1'b1;
      cyc("R10");
      if (k >= 8) highs += pin_o;
    end
    check("R10", "high count", highs[7:0], 8'd16);

    // R7: divided clock, pulses and port writes have no effect
    mode_we = 1'b1; mode_wd = 8'hC0; cyc("R7");
    idle(6, "R7");
    eoc0 = 1'b1; eoc1 = 1'b1; cyc("R4");
    port_we = 1'b1; port_wd = 8'h00; cyc("R8");
    idle(4, "R7");

    // R2: back to port data
    mode_we = 1'b1; mode_wd = 8'h00; cyc("R2");
    idle(2, "R2");
    port_we = 1'b1; port_wd = 8'h40; cyc("R8");
    idle(2, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule